// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire serial bus in front of a byte-wide non-volatile memory model. It oversamples the bus clock and data lines on the system clock, finds Start and Stop conditions, shifts bytes in and out most significant bit first, and answers on the ninth clock of each byte. Its only output to the bus is an enable that pulls the data line low.

A master selects the block with a select byte. That byte carries a fixed type code, two strap bits, the top address bit and a read/write flag. For a write, two address bytes follow, then up to a page of data bytes. The data bytes collect in a page buffer. A Stop copies the buffer into the array through a self-timed cycle. While that cycle runs, the bus is ignored, so a master can poll by sending select bytes until one is acknowledged. Reads come from the current address, from a random address set by a dummy write followed by a repeated Start, or as a sequential stream. A write-protect input blocks all changes to the array.

Top module: `i2c_mem_slave`

## Requirements
- R1: A Start (data falling while clock is high) restarts byte reception from the first bit of a select byte in any bus state, including in the middle of a byte.
- R2: A select byte is acknowledged only when bits 7..4 equal 1010 and bits 3..2 equal the strap inputs {strap_i[1], strap_i[0]}. Otherwise the block stays silent until the next Start.
- R3: A write select (bit 0 = 0) is followed by a high and a low address byte, both acknowledged. The address is {select bit 1, high, low}. The array cell used is that address modulo MEM_DEPTH.
- R4: While wprot_i is high, data bytes are not acknowledged and the array stays unchanged, and no write cycle starts. Select and address bytes are still acknowledged.
- R5: Within a write, the low log2(PAGE_BYTES) address bits wrap inside the page. Only the page slots written in that transaction are copied into the array. Every other cell keeps its contents.
- R6: A Stop after at least one accepted data byte starts a write cycle of max(WRITE_CYCLES, PAGE_BYTES) system clocks. During that cycle Start conditions are ignored and no select byte is acknowledged.
- R7: After a read select (bit 0 = 1), the block sends the byte at the current address and then increments the address across the whole 17-bit space. Each master acknowledge asks for the next byte. A master non-acknowledge ends the transfer.
- R8: A current-address read starts at one past the last byte read or written.
- R9: A random read (write select, two address bytes, repeated Start, read select) returns data from the new address.
- R10: The data-line pull changes only after a falling bus clock edge and never asserts while the master owns the data line during clock high.
- R11: After reset the data line is released and the block waits for a Start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_i | input | 2 | Board strap bits compared against select bits 3..2 |
| wprot_i | input | 1 | 1 blocks all array writes |

## Verification
The closest interaction is between a Start condition and the self-timed commit that a Stop has just launched. Both can be active in the same system clock, and the block has to let the commit win. The bench provokes this by polling with a Start and select byte straight after the Stop of a write. It expects a non-acknowledge there, and an acknowledge for the same poll once the commit window has passed. A second overlap is a Start that arrives partway through a byte. The bench checks it by aborting a select after three bits and confirming that the next full select is acknowledged.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int ADDR_W = 17;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } bus_st_e;

    typedef enum logic [1:0] {
        RL_SEL,
        RL_AHI,
        RL_ALO,
        RL_DATA
    } byte_role_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sda;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic sel_match(logic [7:0] b, logic [1:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:2] == strap);
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(logic [ADDR_W-1:0] a, int pw);
        logic [ADDR_W-1:0] m;
        m = ADDR_W'((1 << pw) - 1);
        return (a & ~m) | ((a + 1'b1) & m);
    endfunction

endpackage

// File: rtl/smem_sync.sv
module smem_sync
    import smem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.sda   = sda_s;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/smem_store.sv
module smem_store
    import smem_pkg::*;
#(
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1500
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]               buf_idx,
    input  logic [7:0]                                  buf_data,
    input  logic                                        buf_clr,
    input  logic                                        commit_go,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]        commit_base,
    input  logic [$clog2(MEM_DEPTH)-1:0]                rd_addr,
    output logic [7:0]                                  rd_data,
    output logic                                        busy
);

    localparam int AW  = $clog2(MEM_DEPTH);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int TW  = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
    localparam int TCW = $clog2(TW + 1);

    logic [7:0]             mem   [MEM_DEPTH];
    logic [7:0]             pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]  pvalid;
    logic [ADDR_W-PW-1:0]   base;
    logic [TCW-1:0]         timer;
    logic [PW-1:0]          slot;
    logic [ADDR_W-1:0]      wr_full;

    assign slot    = timer[PW-1:0];
    assign wr_full = {base, slot};
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf[buf_idx] <= buf_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
            pvalid <= '0;
            busy   <= 1'b0;
            timer  <= '0;
            base   <= '0;
        end else begin
            if (commit_go && !busy) begin
                busy  <= 1'b1;
                timer <= '0;
                base  <= commit_base;
            end else if (busy) begin
                if (timer < TCW'(PAGE_BYTES) && pvalid[slot]) begin
                    mem[wr_full[AW-1:0]] <= pbuf[slot];
                end
                if (timer == TCW'(TW - 1)) begin
                    busy   <= 1'b0;
                    pvalid <= '0;
                end else begin
                    timer <= timer + 1'b1;
                end
            end
            if (buf_clr) begin
                pvalid <= '0;
            end
            if (buf_we) begin
                pvalid[buf_idx] <= 1'b1;
            end
        end
    end

    // R6: the page buffer is never filled while a commit is draining it
    a_r6_no_fill_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !buf_we);

    // R6: a commit request is only raised while no commit is running
    a_r6_no_overlap_commit: assert property (@(posedge clk) disable iff (rst)
        busy |-> !commit_go);

endmodule

// File: rtl/smem_proto.sv
module smem_proto
    import smem_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [1:0]        strap,
    input  logic              wprot,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              sda_pull,
    output logic              buf_we,
    output logic [PW-1:0]     buf_idx,
    output logic [7:0]        buf_data,
    output logic              buf_clr,
    output logic              commit_go,
    output logic [ADDR_W-1:0] addr
);

    bus_st_e    st;
    byte_role_e role;
    logic [3:0] bcnt;
    logic [7:0] sh;
    logic       go_tx;
    logic [7:0] ahi;
    logic       a16;
    logic       pend;
    logic       ack_now;

    always_comb begin
        case (role)
            RL_SEL:  ack_now = sel_match(sh, strap);
            RL_DATA: ack_now = !wprot;
            default: ack_now = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            role      <= RL_SEL;
            bcnt      <= '0;
            sh        <= '0;
            go_tx     <= 1'b0;
            ahi       <= '0;
            a16       <= 1'b0;
            pend      <= 1'b0;
            addr      <= '0;
            sda_pull  <= 1'b0;
            buf_we    <= 1'b0;
            buf_idx   <= '0;
            buf_data  <= '0;
            buf_clr   <= 1'b0;
            commit_go <= 1'b0;
        end else begin
            buf_we    <= 1'b0;
            buf_clr   <= 1'b0;
            commit_go <= 1'b0;
            if (busy) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (ev.start) begin
                st       <= ST_RX;
                role     <= RL_SEL;
                bcnt     <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
                if (pend) begin
                    commit_go <= 1'b1;
                end
                pend <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            sh   <= {sh[6:0], ev.sda};
                            bcnt <= bcnt + 1'b1;
                        end else if (ev.fall && bcnt == 4'd8) begin
                            bcnt  <= '0;
                            go_tx <= 1'b0;
                            if (!ack_now) begin
                                st <= ST_IDLE;
                            end else begin
                                sda_pull <= 1'b1;
                                st       <= ST_RXACK;
                                case (role)
                                    RL_SEL: begin
                                        if (sh[0]) begin
                                            go_tx <= 1'b1;
                                        end else begin
                                            a16  <= sh[1];
                                            role <= RL_AHI;
                                        end
                                    end
                                    RL_AHI: begin
                                        ahi  <= sh;
                                        role <= RL_ALO;
                                    end
                                    RL_ALO: begin
                                        addr    <= {a16, ahi, sh};
                                        role    <= RL_DATA;
                                        pend    <= 1'b0;
                                        buf_clr <= 1'b1;
                                    end
                                    default: begin
                                        buf_we   <= 1'b1;
                                        buf_idx  <= addr[PW-1:0];
                                        buf_data <= sh;
                                        addr     <= page_step(addr, PW);
                                        pend     <= 1'b1;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (ev.fall) begin
                            if (go_tx) begin
                                sh       <= rd_data;
                                sda_pull <= ~rd_data[7];
                                addr     <= addr + 1'b1;
                                bcnt     <= '0;
                                st       <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                st       <= ST_TXACK;
                            end else begin
                                sh       <= {sh[6:0], 1'b0};
                                sda_pull <= ~sh[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev.rise && ev.sda) begin
                            st <= ST_IDLE;
                        end else if (ev.fall) begin
                            sh       <= rd_data;
                            sda_pull <= ~rd_data[7];
                            addr     <= addr + 1'b1;
                            bcnt     <= '0;
                            st       <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a Start seen outside a commit re-arms reception at bit zero
    a_r1_start_rearms: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !busy) |=> (st == ST_RX && bcnt == 4'd0));

    // R6: the data line stays released while a commit runs
    a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    // R10: the pull only turns on just after a falling bus clock
    a_r10_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(ev.fall));

    // R4: no byte enters the page buffer when protection was active
    a_r4_wp_blocks_buffer: assert property (@(posedge clk) disable iff (rst)
        wprot |=> !buf_we);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import smem_pkg::*;
#(
    parameter int MEM_DEPTH    = 512,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1500,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] strap_i,
    input  logic       wprot_i
);

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int PW = $clog2(PAGE_BYTES);

    line_ev_t          ev;
    logic              busy;
    logic [7:0]        rd_data;
    logic              buf_we;
    logic [PW-1:0]     buf_idx;
    logic [7:0]        buf_data;
    logic              buf_clr;
    logic              commit_go;
    logic [ADDR_W-1:0] addr;

    smem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smem_proto #(.PW(PW)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap_i),
        .wprot     (wprot_i),
        .busy      (busy),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull_o),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .buf_data  (buf_data),
        .buf_clr   (buf_clr),
        .commit_go (commit_go),
        .addr      (addr)
    );

    smem_store #(
        .MEM_DEPTH    (MEM_DEPTH),
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .buf_we      (buf_we),
        .buf_idx     (buf_idx),
        .buf_data    (buf_data),
        .buf_clr     (buf_clr),
        .commit_go   (commit_go),
        .commit_base (addr[ADDR_W-1:PW]),
        .rd_addr     (addr[AW-1:0]),
        .rd_data     (rd_data),
        .busy        (busy)
    );

    // R11: the data line is released on the first cycle out of reset
    a_r11_released_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !sda_pull_o);

endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;

    localparam int DEPTH = 512;
    localparam int WCYC  = 1500;
    localparam int Q     = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wprot = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       pull;
    logic       sda_line;

    int  checks = 0;
    int  errors = 0;
    int  viol = 0;
    bit  mown = 0;
    bit  done = 0;
    logic [7:0] ref_mem [DEPTH];
    int  ref_addr = 0;
    logic [7:0] wq [$];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~pull;

    i2c_mem_slave #(.MEM_DEPTH(DEPTH), .WRITE_CYCLES(WCYC)) u_i2c_mem_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .strap_i    (strap),
        .wprot_i    (wprot)
    );

    // per-clock model comparison: slave must never pull while master owns the line
    always @(negedge clk) begin
        if (mown && scl_m && pull) viol++;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sel(logic a16, logic rw);
        return {4'hA, strap, a16, rw};
    endfunction

    task automatic m_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(2 * Q);
    endtask

    task automatic m_bit(input logic b, input bit own, output logic s);
        sda_m = b; hold(Q);
        scl_m = 1'b1; mown = own; hold(Q);
        s = sda_line; hold(Q);
        scl_m = 1'b0; mown = 0; hold(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], 1, s);
        m_bit(1'b1, 0, s);
        ack = !s;
    endtask

    task automatic m_rbyte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, 0, s);
            d[i] = s;
        end
        m_bit(!give_ack, 1, s);
    endtask

    task automatic do_write(input int a, input bit wp, output int n);
        bit ack;
        bit pv [128];
        logic [7:0] pd [128];
        n = 0;
        for (int i = 0; i < 128; i++) pv[i] = 0;
        wprot = wp;
        m_start();
        m_wbyte(sel(a[16], 1'b0), ack); chk(ack, "R2 write select ack", ack, 1);
        m_wbyte(a[15:8], ack);          chk(ack, "R3 high address ack", ack, 1);
        m_wbyte(a[7:0], ack);           chk(ack, "R3 low address ack", ack, 1);
        ref_addr = a;
        foreach (wq[i]) begin
            m_wbyte(wq[i], ack);
            chk(ack == !wp, "R4 R5 data ack", ack, !wp);
            if (!ack) break;
            pd[ref_addr & 127] = wq[i];
            pv[ref_addr & 127] = 1;
            n++;
            ref_addr = (ref_addr & ~127) | ((ref_addr + 1) & 127);
        end
        m_stop();
        wprot = 1'b0;
        if (n > 0) begin
            for (int s = 0; s < 128; s++)
                if (pv[s]) ref_mem[((ref_addr & ~127) | s) % DEPTH] = pd[s];
        end
    endtask

    task automatic read_stream(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            m_rbyte(i != n - 1, d);
            chk(d == ref_mem[ref_addr % DEPTH], req, d, ref_mem[ref_addr % DEPTH]);
            ref_addr = (ref_addr + 1) & 32'h1FFFF;
        end
        m_stop();
    endtask

    task automatic do_read_rand(input int a, input int n);
        bit ack;
        m_start();
        m_wbyte(sel(a[16], 1'b0), ack); chk(ack, "R9 dummy write select ack", ack, 1);
        m_wbyte(a[15:8], ack);          chk(ack, "R9 high address ack", ack, 1);
        m_wbyte(a[7:0], ack);           chk(ack, "R9 low address ack", ack, 1);
        ref_addr = a;
        m_start();
        m_wbyte(sel(1'b0, 1'b1), ack);  chk(ack, "R9 read select ack", ack, 1);
        read_stream(n, "R7 R9 read data");
    endtask

    task automatic do_read_cur(input int n);
        bit ack;
        m_start();
        m_wbyte(sel(1'b0, 1'b1), ack); chk(ack, "R8 read select ack", ack, 1);
        read_stream(n, "R8 current address data");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        bit ack;
        int n;
        logic s;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        hold(10);
        rst = 1'b0;
        hold(5);
        chk(pull == 1'b0, "R11 line released after reset", pull, 0);

        // byte write, then poll during the commit
        wq = {8'hA5, 8'h3C, 8'h96};
        do_write(32'h00010, 1'b0, n);
        m_start();
        m_wbyte(sel(1'b0, 1'b0), ack);
        chk(!ack, "R6 select ignored during write cycle", ack, 0);
        m_stop();
        hold(WCYC);
        m_start();
        m_wbyte(sel(1'b0, 1'b0), ack);
        chk(ack, "R6 select acked after write cycle", ack, 1);
        m_stop();

        // random read then current-address reads
        do_read_rand(32'h00010, 1);
        do_read_cur(1);
        do_read_cur(2);

        // page wrap inside a page
        wq = {8'h11, 8'h22, 8'h33, 8'h44};
        do_write(32'h0007E, 1'b0, n);
        chk(n == 4, "R5 all page bytes accepted", n, 4);
        hold(WCYC + 20);
        do_read_rand(32'h0007E, 4);
        do_read_rand(32'h00000, 2);
        do_read_rand(32'h00010, 1);

        // top address bit from the select byte, cell modulo depth
        wq = {8'h5A};
        do_write(32'h10020, 1'b0, n);
        hold(WCYC + 20);
        do_read_rand(32'h00020, 1);

        // write protect: data refused, no write cycle started
        wq = {8'hFF};
        do_write(32'h00010, 1'b1, n);
        chk(n == 0, "R4 protected data refused", n, 0);
        m_start();
        m_wbyte(sel(1'b0, 1'b0), ack);
        chk(ack, "R4 no write cycle after protected write", ack, 1);
        m_stop();
        do_read_rand(32'h00010, 1);

        // wrong type code and wrong strap
        m_start();
        m_wbyte({4'hB, strap, 2'b00}, ack);
        chk(!ack, "R2 wrong type code refused", ack, 0);
        m_wbyte(8'h00, ack);
        chk(!ack, "R2 silent after mismatch", ack, 0);
        m_stop();
        m_start();
        m_wbyte({4'hA, ~strap, 2'b00}, ack);
        chk(!ack, "R2 wrong strap refused", ack, 0);
        m_stop();

        // Start in the middle of a byte restarts reception
        m_start();
        for (int i = 0; i < 3; i++) m_bit(1'b1, 1, s);
        m_start();
        m_wbyte(sel(1'b0, 1'b0), ack);
        chk(ack, "R1 select after aborted byte", ack, 1);
        m_stop();

        chk(viol == 0, "R10 no pull while master owns line", viol, 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

endmodule